// File: doc/BRIEF.md
# Half-Bridge Command Interlock Conditioner

This block sits between a PWM controller and the gate drivers of a three-phase bridge built from six switches. Each phase receives one command that asks for the upper switch (active low) and one that asks for the lower switch (active high). The block turns them into six active-high gate enables.

On the way through, every command is synchronised. A request for both switches of one phase is refused. A minimum off interval is guaranteed before any switch of a phase turns on. All gates are pulled off while the block is disabled or while the fault manager asks for a shutdown.

The off interval is taken from a cycle-count setting plus a fixed floor of two cycles, so a setting of zero still gives a real gap. Each phase also reports, per switch, whether the switch is on and its command still asks for it. A short-circuit monitor can use this status to decide when to watch the switch.

Top module: `half_bridge_interlock`

## Requirements
- R1: A low on `hi_cmd_n_i[p]` requests the upper gate of phase p and a high on `lo_cmd_i[p]` requests the lower gate. Each granted request drives the matching `hi_gate_o[p]` / `lo_gate_o[p]` high. Every phase is handled on its own.
- R2: While a phase has both requests active (`hi_cmd_n_i[p]`=0 and `lo_cmd_i[p]`=1), neither of its gates is high, including a gate that was already on.
- R3: Between any gate of a phase going low and any gate of the same phase going high, both gates of that phase stay low for at least `dead_cfg_i`+2 clock cycles. When the opposite request is already waiting, the gap is exactly `dead_cfg_i`+2 cycles. A longer gap that the controller already leaves is kept unchanged.
- R4: A larger `dead_cfg_i` gives a longer gap: setting 0 gives 2 cycles and setting 5 gives 7 cycles.
- R5: While `rst_ni` is low, all gate and status outputs are low. After reset, synchronised inputs start in their off state (upper command high, lower command low, enable low).
- R6: A granted gate stays high for as long as its request stays, with no limit on the on time (0 % to 100 % duty).
- R7: `enable_i` low for three consecutive clock edges makes all six gates low after the next edge.
- R8: `shutdown_i` high for three consecutive edges forces all gates low. Once it drops, the gates follow the present command pattern again with no reset.
- R9: A change of a command reaches the gate on the third rising edge after it is applied: two synchroniser stages and one output register. A turn-on waits longer if the gap of R3 has not yet elapsed.
- R10: `hi_armed_o[p]` (`lo_armed_o[p]`) is high exactly when that gate is high and its synchronised request is still active. It therefore falls one edge before the gate when the request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_cmd_n_i | input | NUM_PH (3) | Upper-switch requests, active low, one bit per phase |
| lo_cmd_i | input | NUM_PH (3) | Lower-switch requests, active high, one bit per phase |
| enable_i | input | 1 | Block enable; low forces all gates off |
| shutdown_i | input | 1 | Shutdown request from the fault manager; high forces all gates off |
| dead_cfg_i | input | DT_W (8) | Extra off cycles added to the two-cycle floor |
| hi_gate_o | output | NUM_PH (3) | Upper gate enables, active high |
| lo_gate_o | output | NUM_PH (3) | Lower gate enables, active high |
| hi_armed_o | output | NUM_PH (3) | Upper gate on and still requested |
| lo_armed_o | output | NUM_PH (3) | Lower gate on and still requested |

## Verification
The bench measures the off gap at sample resolution for a direct swap at two settings. A design that counts from the wrong edge shows a gap one cycle short or long, and one that ignores the setting shows the same gap for both.

It also swaps with a controller gap both shorter and longer than the floor. A design that trusts the controller's gap, or that adds its own gap on top of a long one, fails there.

It applies both-on requests to an idle phase and to a phase that is already on. A design that lets the older grant survive leaves a gate high. Enable, shutdown and release are exercised to catch gates that stay latched off after release. The exact edge on which a gate and its status bit change is sampled, which exposes a missing or extra synchroniser stage.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    // Number of synchroniser stages in front of the logic.
    localparam int unsigned SYNC_DEPTH = 2;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    // Decide which side of a phase is wanted; a conflicting request wants neither.
    function automatic gate_pair_t pick_side(input logic hi_req, input logic lo_req,
                                             input logic allow);
        gate_pair_t r;
        r.hi = allow & hi_req & ~lo_req;
        r.lo = allow & lo_req & ~hi_req;
        return r;
    endfunction

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int unsigned W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/hbi_phase.sv
module hbi_phase
    import hbi_pkg::*;
#(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hi_req_i,
    input  logic             lo_req_i,
    input  logic             allow_i,
    input  logic [CNT_W-1:0] gap_i,
    output logic             hi_gate_o,
    output logic             lo_gate_o,
    output logic             hi_armed_o,
    output logic             lo_armed_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        gate_pair_t       gate;
        logic [CNT_W-1:0] off_cnt;  // cycles with both gates low, counted at the edge
    } ph_state_t;

    ph_state_t  st_d, st_q;
    gate_pair_t want;
    logic       idle;
    logic       gap_done;

    always_comb begin
        want     = pick_side(hi_req_i, lo_req_i, allow_i);
        idle     = ~st_q.gate.hi & ~st_q.gate.lo;
        gap_done = idle & (st_q.off_cnt >= gap_i);

        st_d         = st_q;
        // A gate may stay on while wanted; it may only start after a full gap.
        st_d.gate.hi = want.hi & (st_q.gate.hi | gap_done);
        st_d.gate.lo = want.lo & (st_q.gate.lo | gap_done);

        if (!idle) begin
            st_d.off_cnt = CNT_ONE;
        end else if (st_q.off_cnt != CNT_MAX) begin
            st_d.off_cnt = st_q.off_cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.gate    <= '0;
            st_q.off_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_gate_o  = st_q.gate.hi;
    assign lo_gate_o  = st_q.gate.lo;
    assign hi_armed_o = st_q.gate.hi & want.hi;
    assign lo_armed_o = st_q.gate.lo & want.lo;
endmodule

// File: rtl/half_bridge_interlock.sv
module half_bridge_interlock
    import hbi_pkg::*;
#(
    parameter int unsigned NUM_PH   = 3,
    parameter int unsigned DT_W     = 8,
    parameter int unsigned MIN_DEAD = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_PH-1:0] hi_cmd_n_i,
    input  logic [NUM_PH-1:0] lo_cmd_i,
    input  logic              enable_i,
    input  logic              shutdown_i,
    input  logic [DT_W-1:0]   dead_cfg_i,
    output logic [NUM_PH-1:0] hi_gate_o,
    output logic [NUM_PH-1:0] lo_gate_o,
    output logic [NUM_PH-1:0] hi_armed_o,
    output logic [NUM_PH-1:0] lo_armed_o
);
    localparam int unsigned      CNT_W = DT_W + 1;
    localparam logic [CNT_W-1:0] MIN_W = CNT_W'(MIN_DEAD);

    logic [NUM_PH-1:0] hi_n_s;
    logic [NUM_PH-1:0] lo_s;
    logic [1:0]        ctl_s;   // {shutdown, enable}
    logic              allow;
    logic [CNT_W-1:0]  gap;

    hbi_sync #(.W(NUM_PH), .RST_VAL({NUM_PH{1'b1}})) u_sync_hi (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hi_cmd_n_i), .q_o(hi_n_s)
    );

    hbi_sync #(.W(NUM_PH), .RST_VAL('0)) u_sync_lo (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lo_cmd_i), .q_o(lo_s)
    );

    hbi_sync #(.W(2), .RST_VAL(2'b10)) u_sync_ctl (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i({shutdown_i, enable_i}), .q_o(ctl_s)
    );

    always_comb begin
        allow = ctl_s[0] & ~ctl_s[1];
        gap   = {1'b0, dead_cfg_i} + MIN_W;
    end

    for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
        hbi_phase #(.CNT_W(CNT_W)) u_phase (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .hi_req_i   (~hi_n_s[p]),
            .lo_req_i   (lo_s[p]),
            .allow_i    (allow),
            .gap_i      (gap),
            .hi_gate_o  (hi_gate_o[p]),
            .lo_gate_o  (lo_gate_o[p]),
            .hi_armed_o (hi_armed_o[p]),
            .lo_armed_o (lo_armed_o[p])
        );
    end
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
    parameter int unsigned NUM_PH   = 3,
    parameter int unsigned DT_W     = 8,
    parameter int unsigned MIN_DEAD = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_PH-1:0] hi_cmd_n_i,
    input logic [NUM_PH-1:0] lo_cmd_i,
    input logic              enable_i,
    input logic              shutdown_i,
    input logic [DT_W-1:0]   dead_cfg_i,
    input logic [NUM_PH-1:0] hi_gate_o,
    input logic [NUM_PH-1:0] lo_gate_o,
    input logic [NUM_PH-1:0] hi_armed_o,
    input logic [NUM_PH-1:0] lo_armed_o
);
    localparam int unsigned      CNT_W = DT_W + 1;
    localparam logic [CNT_W-1:0] MIN_W = CNT_W'(MIN_DEAD);

    logic [CNT_W-1:0] need;
    assign need = {1'b0, dead_cfg_i} + MIN_W;

    AST_ENABLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!enable_i && !$past(enable_i) && !$past(enable_i, 2))
        |=> (hi_gate_o == '0 && lo_gate_o == '0)); // R7

    AST_SHUTDOWN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shutdown_i && $past(shutdown_i) && $past(shutdown_i, 2))
        |=> (hi_gate_o == '0 && lo_gate_o == '0)); // R8

    for (genvar p = 0; p < NUM_PH; p++) begin : g_chk
        logic [CNT_W-1:0] run_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                run_q <= '0;
            end else if (hi_gate_o[p] || lo_gate_o[p]) begin
                run_q <= '0;
            end else if (run_q != '1) begin
                run_q <= run_q + CNT_W'(1);
            end
        end

        AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(hi_gate_o[p] && lo_gate_o[p])); // R3

        AST_GAP_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hi_gate_o[p] && !$past(hi_gate_o[p])) |-> (run_q >= need)); // R3

        AST_GAP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lo_gate_o[p] && !$past(lo_gate_o[p])) |-> (run_q >= need)); // R3

        AST_CONFLICT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!hi_cmd_n_i[p] && lo_cmd_i[p] && !$past(hi_cmd_n_i[p]) && $past(lo_cmd_i[p])
             && !$past(hi_cmd_n_i[p], 2) && $past(lo_cmd_i[p], 2))
            |=> (!hi_gate_o[p] && !lo_gate_o[p])); // R2

        AST_ARMED_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
            hi_armed_o[p] |-> hi_gate_o[p]); // R10

        AST_ARMED_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lo_armed_o[p] |-> lo_gate_o[p]); // R10
    end
endmodule

bind half_bridge_interlock hbi_checker #(
    .NUM_PH(NUM_PH), .DT_W(DT_W), .MIN_DEAD(MIN_DEAD)
) u_hbi_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .hi_cmd_n_i(hi_cmd_n_i), .lo_cmd_i(lo_cmd_i),
    .enable_i(enable_i), .shutdown_i(shutdown_i), .dead_cfg_i(dead_cfg_i),
    .hi_gate_o(hi_gate_o), .lo_gate_o(lo_gate_o),
    .hi_armed_o(hi_armed_o), .lo_armed_o(lo_armed_o)
);

// File: tb/half_bridge_interlock_test.sv
`timescale 1ns/1ps
module half_bridge_interlock_test;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic [2:0] hi_cmd_n_i = 3'b111;
    logic [2:0] lo_cmd_i = 3'b000;
    logic       enable_i = 1'b0;
    logic       shutdown_i = 1'b0;
    logic [7:0] dead_cfg_i = 8'd0;
    logic [2:0] hi_gate_o, lo_gate_o, hi_armed_o, lo_armed_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2 clk = ~clk;   // 250 MHz

    half_bridge_interlock uut (
        .clk_i(clk), .rst_ni(rst_ni), .hi_cmd_n_i(hi_cmd_n_i), .lo_cmd_i(lo_cmd_i),
        .enable_i(enable_i), .shutdown_i(shutdown_i), .dead_cfg_i(dead_cfg_i),
        .hi_gate_o(hi_gate_o), .lo_gate_o(lo_gate_o),
        .hi_armed_o(hi_armed_o), .lo_armed_o(lo_armed_o)
    );

    // {hi_cmd_n[2:0], lo_cmd[2:0], enable, shutdown, exp_hi[2:0], exp_lo[2:0]}
    localparam int NVEC = 12;
    localparam logic [13:0] VEC [NVEC] = '{
        14'b111_000_1_0_000_000,
        14'b110_000_1_0_001_000,
        14'b111_001_1_0_000_001,
        14'b110_001_1_0_000_000,
        14'b010_100_1_0_001_000,
        14'b101_101_1_0_010_101,
        14'b101_101_0_0_000_000,
        14'b101_101_1_1_000_000,
        14'b101_101_1_0_010_101,
        14'b000_000_1_0_111_000,
        14'b111_111_1_0_000_111,
        14'b000_111_1_0_000_000
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts samples with both gates of a phase low between switching off and on.
    task automatic gap_check(input int ph, input int exp_gap, input string req);
        int n = 0;
        int guard = 0;
        while ((hi_gate_o[ph] || lo_gate_o[ph]) && guard < 100) begin
            @(negedge clk); guard++;
        end
        while (!(hi_gate_o[ph] || lo_gate_o[ph]) && guard < 200) begin
            n++; @(negedge clk); guard++;
        end
        check(n == exp_gap, req, n, exp_gap);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R5: outputs low in reset even with a request present
        hi_cmd_n_i = 3'b110; enable_i = 1'b1;
        repeat (5) @(negedge clk);
        check(hi_gate_o == 0 && lo_gate_o == 0, "R5 gates in reset", {hi_gate_o, lo_gate_o}, 0);
        check(hi_armed_o == 0 && lo_armed_o == 0, "R5 status in reset", {hi_armed_o, lo_armed_o}, 0);
        rst_ni = 1'b1;
        repeat (20) @(negedge clk);

        // R1 R2 R7 R8 vector table, dead setting 0
        for (int i = 0; i < NVEC; i++) begin
            hi_cmd_n_i = VEC[i][13:11];
            lo_cmd_i   = VEC[i][10:8];
            enable_i   = VEC[i][7];
            shutdown_i = VEC[i][6];
            repeat (12) @(negedge clk);
            check(hi_gate_o == VEC[i][5:3], "R1/R2/R7/R8 upper", hi_gate_o, VEC[i][5:3]);
            check(lo_gate_o == VEC[i][2:0], "R1/R2/R7/R8 lower", lo_gate_o, VEC[i][2:0]);
        end

        // R3: direct swap at setting 0
        hi_cmd_n_i = 3'b110; lo_cmd_i = 3'b000; dead_cfg_i = 8'd0;
        repeat (20) @(negedge clk);
        hi_cmd_n_i = 3'b111; lo_cmd_i = 3'b001;
        gap_check(0, 2, "R3 swap gap setting 0");
        repeat (20) @(negedge clk);

        // R4: larger setting, lower to upper swap
        dead_cfg_i = 8'd5;
        hi_cmd_n_i = 3'b110; lo_cmd_i = 3'b000;
        gap_check(0, 7, "R4 swap gap setting 5");
        repeat (20) @(negedge clk);

        // R3: controller gap shorter than the floor is stretched
        hi_cmd_n_i = 3'b111;
        fork
            gap_check(0, 7, "R3 short controller gap");
            begin repeat (3) @(negedge clk); lo_cmd_i = 3'b001; end
        join
        repeat (20) @(negedge clk);

        // R3: controller gap longer than the floor is kept as is
        lo_cmd_i = 3'b000;
        fork
            gap_check(0, 20, "R3 long controller gap");
            begin repeat (20) @(negedge clk); hi_cmd_n_i = 3'b110; end
        join
        repeat (20) @(negedge clk);

        // R9 R10: latency of turn-off and status
        dead_cfg_i = 8'd0;
        hi_cmd_n_i = 3'b101; lo_cmd_i = 3'b000;
        repeat (20) @(negedge clk);
        check(hi_armed_o[1] == 1'b1, "R10 status while on", hi_armed_o[1], 1);
        hi_cmd_n_i = 3'b111;
        @(negedge clk);
        @(negedge clk);
        check(hi_gate_o[1] == 1'b1, "R9 gate still on after two edges", hi_gate_o[1], 1);
        check(hi_armed_o[1] == 1'b0, "R10 status drops first", hi_armed_o[1], 0);
        @(negedge clk);
        check(hi_gate_o[1] == 1'b0, "R9 gate off on third edge", hi_gate_o[1], 0);

        // R9: turn-on latency after a long idle
        repeat (20) @(negedge clk);
        hi_cmd_n_i = 3'b101;
        @(negedge clk);
        @(negedge clk);
        check(hi_gate_o[1] == 1'b0, "R9 gate not yet on", hi_gate_o[1], 0);
        @(negedge clk);
        check(hi_gate_o[1] == 1'b1, "R9 gate on at third edge", hi_gate_o[1], 1);

        // R6: no on-time limit
        repeat (400) @(negedge clk);
        check(hi_gate_o[1] == 1'b1 && hi_armed_o[1] == 1'b1, "R6 long hold",
              {hi_gate_o[1], hi_armed_o[1]}, 3);

        // R2: conflicting request on a phase that is already on
        lo_cmd_i = 3'b010;
        repeat (3) @(negedge clk);
        check(hi_gate_o[1] == 1'b0 && lo_gate_o[1] == 1'b0, "R2 on phase dropped",
              {hi_gate_o[1], lo_gate_o[1]}, 0);
        repeat (20) @(negedge clk);
        check(hi_gate_o[1] == 1'b0 && lo_gate_o[1] == 1'b0, "R2 stays off",
              {hi_gate_o[1], lo_gate_o[1]}, 0);

        // R7: enable timing, then realignment
        lo_cmd_i = 3'b000;
        repeat (20) @(negedge clk);
        enable_i = 1'b0;
        repeat (3) @(negedge clk);
        check(hi_gate_o == 0 && lo_gate_o == 0, "R7 off three edges after enable low",
              {hi_gate_o, lo_gate_o}, 0);
        enable_i = 1'b1;
        repeat (20) @(negedge clk);
        check(hi_gate_o == 3'b010, "R7 follows after enable", hi_gate_o, 2);

        // R8: shutdown and release without reset
        shutdown_i = 1'b1;
        repeat (3) @(negedge clk);
        check(hi_gate_o == 0 && lo_gate_o == 0, "R8 off after shutdown",
              {hi_gate_o, lo_gate_o}, 0);
        shutdown_i = 1'b0;
        repeat (20) @(negedge clk);
        check(hi_gate_o == 3'b010 && lo_gate_o == 0, "R8 realign after release",
              {hi_gate_o, lo_gate_o}, 16);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule